// File: doc/BRIEF.md
# Bus Master Arbitration and Clock-Low Supervisor

This block sits beside the bit engine of a two-wire, open-drain bus master. On every clock it compares the data level the master intends to put on the wire with the level sampled back from the wire. Any difference seen while the clock line is high means another master has won the bus. The block then raises an arbitration-lost pulse. If the loss happened while the slave address was being sent, it also raises a hand-over pulse, so that slave-side logic can keep listening for its own address.

The block also watches the sampled clock line. It flags when the master has released the clock but the line is still held low by a slave or another master. It adds up, in units of a system timebase tick, how long the clock has been low during the current transaction. When the total reaches the limit, it aborts the transaction and sets a sticky status bit. Software clears that bit by writing a 1.

After any abort the block releases both lines. This lasts until the controller returns the phase input to idle. The block does not generate the clock waveform.

Top module: `mm_arb_monitor`

## Requirements
- R1: The phase input is encoded 00 idle, 01 address, 10 transmit, 11 receive. In the address or transmit phase, a cycle with sampled clock high and sampled data different from driven data makes `arb_lost_o` a one-cycle pulse in the next cycle.
- R2: A data mismatch while the sampled clock is low causes no arbitration loss.
- R3: In the receive phase a data mismatch never causes an arbitration loss, even with the clock high.
- R4: An arbitration loss taken in the address phase also pulses `to_slave_o` in the same cycle as `arb_lost_o`. A loss in the transmit phase does not.
- R5: From the cycle after an abort until the phase input returns to idle, `sda_out_o` and `scl_out_o` are both 1 whatever the driven inputs are. No further abort pulse occurs in that time.
- R6: When the cumulative clock-low count of the transaction reaches LOW_LIMIT, `timeout_abort_o` pulses for one cycle in the next cycle and `lowto_sts_o` becomes 1.
- R7: The count advances only on cycles with `tick_i` high and sampled clock low. Low intervals add up across the transaction, including low time caused by another device while this master has released the clock.
- R8: A start condition (data falls while the clock stays high) or a stop condition (data rises while the clock stays high) on the sampled lines clears the count.
- R9: `lowto_sts_o` stays 1 until `sts_clr_i` is 1 for a cycle. A new timeout in that same cycle keeps it at 1.
- R10: In the idle phase there is no comparison, no counting and no abort.
- R11: Outside a release, when the phase is not idle, the master drives the clock as 1 and the sampled clock is 0, `stretch_o` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick for the clock-low count |
| phase_i | input | 2 | Transaction phase: 00 idle, 01 address, 10 transmit, 11 receive |
| sda_drv_i | input | 1 | Data level the bit engine wants to drive (1 = release) |
| sda_in_i | input | 1 | Sampled data line |
| scl_drv_i | input | 1 | Clock level the bit engine wants to drive (1 = release) |
| scl_in_i | input | 1 | Sampled clock line |
| sts_clr_i | input | 1 | Write-1-to-clear strobe for the timeout status |
| sda_out_o | output | 1 | Data level to the pad, forced to 1 after an abort |
| scl_out_o | output | 1 | Clock level to the pad, forced to 1 after an abort |
| arb_lost_o | output | 1 | Arbitration lost pulse |
| to_slave_o | output | 1 | Hand-over to slave listening pulse |
| timeout_abort_o | output | 1 | Clock-low timeout abort pulse |
| lowto_sts_o | output | 1 | Sticky clock-low timeout status |
| stretch_o | output | 1 | Clock held low by another device |

## Verification
An arbitration loss needs the clock high and the timeout count needs the clock low, so those two aborts cannot fall in one cycle. The collision that can happen is between the timeout setting the status bit and software clearing it. The bench builds up LOW_LIMIT-1 low ticks and then puts the final tick and the clear strobe in the same cycle. It expects the timeout pulse and a status bit that stays at 1, and a later clear alone then drops it.

// File: rtl/arbmon_pkg.sv
`timescale 1ns/1ps
package arbmon_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_TX   = 2'b10,
    PH_RX   = 2'b11
  } phase_e;
endpackage

// File: rtl/arbmon_rst_sync.sv
`timescale 1ns/1ps
module arbmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int unsigned LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[LAST];
endmodule

// File: rtl/arbmon_line_sampler.sv
`timescale 1ns/1ps
module arbmon_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in_i,
  input  logic scl_in_i,
  output logic start_o,
  output logic stop_o
);
  logic sda_q, scl_q;
  logic sda_d, scl_d;

  always_comb begin
    sda_d = sda_in_i;
    scl_d = scl_in_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_d;
      scl_q <= scl_d;
    end
  end

  // a data edge while the clock stays high marks a bus condition
  assign start_o = scl_q & scl_in_i &  sda_q & ~sda_in_i;
  assign stop_o  = scl_q & scl_in_i & ~sda_q &  sda_in_i;
endmodule

// File: rtl/arbmon_cmp.sv
`timescale 1ns/1ps
module arbmon_cmp
  import arbmon_pkg::*;
(
  input  logic   en_i,
  input  phase_e phase_i,
  input  logic   scl_in_i,
  input  logic   sda_drv_i,
  input  logic   sda_in_i,
  output logic   mism_o
);
  logic cmp_window;

  always_comb begin
    // receive data may be pulled low by the slave: no compare there
    cmp_window = en_i & scl_in_i & (phase_i != PH_RX);
    mism_o     = cmp_window & (sda_drv_i ^ sda_in_i);
  end
endmodule

// File: rtl/arbmon_low_timer.sv
`timescale 1ns/1ps
module arbmon_low_timer #(
  parameter int unsigned LOW_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LOW_LIMIT < 2) ? 1 : $clog2(LOW_LIMIT);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LOW_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expire_o = inc_i & ~clr_i & (cnt_q == LAST_VAL);
    cnt_en   = clr_i | inc_i;
    cnt_d    = cnt_q;
    if (clr_i || expire_o) cnt_d = '0;
    else if (inc_i)        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mm_arb_monitor.sv
`timescale 1ns/1ps
module mm_arb_monitor
  import arbmon_pkg::*;
#(
  parameter int unsigned LOW_LIMIT  = 1000,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] phase_i,
  input  logic       sda_drv_i,
  input  logic       sda_in_i,
  input  logic       scl_drv_i,
  input  logic       scl_in_i,
  input  logic       sts_clr_i,
  output logic       sda_out_o,
  output logic       scl_out_o,
  output logic       arb_lost_o,
  output logic       to_slave_o,
  output logic       timeout_abort_o,
  output logic       lowto_sts_o,
  output logic       stretch_o
);
  logic   rst_n_s;
  phase_e phase;
  logic   active;
  logic   start_det, stop_det;
  logic   mism, expire, tmr_inc, tmr_clr;

  logic rel_q, arb_q, slv_q, to_q, sts_q, str_q;
  logic rel_d, arb_d, slv_d, to_d, sts_d, str_d;

  arbmon_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign phase  = phase_e'(phase_i);
  assign active = (phase != PH_IDLE);

  arbmon_line_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sda_in_i (sda_in_i),
    .scl_in_i (scl_in_i),
    .start_o  (start_det),
    .stop_o   (stop_det)
  );

  arbmon_cmp u_cmp (
    .en_i      (active & ~rel_q),
    .phase_i   (phase),
    .scl_in_i  (scl_in_i),
    .sda_drv_i (sda_drv_i),
    .sda_in_i  (sda_in_i),
    .mism_o    (mism)
  );

  always_comb begin
    tmr_inc = active & ~rel_q & tick_i & ~scl_in_i & ~start_det & ~stop_det;
    tmr_clr = ~active | start_det | stop_det | mism;
  end

  arbmon_low_timer #(.LOW_LIMIT(LOW_LIMIT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (tmr_clr),
    .inc_i    (tmr_inc),
    .expire_o (expire)
  );

  // next-state logic
  always_comb begin
    rel_d = active & (rel_q | mism | expire);
    arb_d = mism;
    slv_d = mism & (phase == PH_ADDR);
    to_d  = expire;
    sts_d = expire | (sts_q & ~sts_clr_i);
    str_d = active & ~rel_q & scl_drv_i & ~scl_in_i;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rel_q <= 1'b0;
      arb_q <= 1'b0;
      slv_q <= 1'b0;
      to_q  <= 1'b0;
      sts_q <= 1'b0;
      str_q <= 1'b0;
    end else begin
      rel_q <= rel_d;
      arb_q <= arb_d;
      slv_q <= slv_d;
      to_q  <= to_d;
      sts_q <= sts_d;
      str_q <= str_d;
    end
  end

  assign sda_out_o       = rel_q | sda_drv_i;
  assign scl_out_o       = rel_q | scl_drv_i;
  assign arb_lost_o      = arb_q;
  assign to_slave_o      = slv_q;
  assign timeout_abort_o = to_q;
  assign lowto_sts_o     = sts_q;
  assign stretch_o       = str_q;
endmodule

// File: rtl/mm_arb_monitor_chk.sv
`timescale 1ns/1ps
module mm_arb_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase_i,
  input logic       scl_in_i,
  input logic       sts_clr_i,
  input logic       sda_out_o,
  input logic       scl_out_o,
  input logic       arb_lost_o,
  input logic       to_slave_o,
  input logic       timeout_abort_o,
  input logic       lowto_sts_o
);
  p_cmp_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_in_i |=> !arb_lost_o);

  p_rx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 2'b11) |=> !arb_lost_o);

  p_slave_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    to_slave_o |-> ($past(phase_i) == 2'b01));

  p_slave_with_lost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    to_slave_o |-> arb_lost_o);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_o || timeout_abort_o) |-> (sda_out_o && scl_out_o));

  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_o || timeout_abort_o) |=> !(arb_lost_o || timeout_abort_o));

  p_to_sets_sts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_abort_o |-> lowto_sts_o);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lowto_sts_o && !sts_clr_i) |=> lowto_sts_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == 2'b00) |=> (!arb_lost_o && !timeout_abort_o));
endmodule

bind mm_arb_monitor mm_arb_monitor_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .phase_i         (phase_i),
  .scl_in_i        (scl_in_i),
  .sts_clr_i       (sts_clr_i),
  .sda_out_o       (sda_out_o),
  .scl_out_o       (scl_out_o),
  .arb_lost_o      (arb_lost_o),
  .to_slave_o      (to_slave_o),
  .timeout_abort_o (timeout_abort_o),
  .lowto_sts_o     (lowto_sts_o)
);

// File: tb/mm_arb_monitor_tb.sv
`timescale 1ns/1ps
module mm_arb_monitor_tb;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_i, sda_drv_i, sda_in_i, scl_drv_i, scl_in_i, sts_clr_i;
  logic [1:0] phase_i;
  logic sda_out_o, scl_out_o, arb_lost_o, to_slave_o, timeout_abort_o, lowto_sts_o, stretch_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mm_arb_monitor #(.LOW_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .phase_i(phase_i),
    .sda_drv_i(sda_drv_i), .sda_in_i(sda_in_i), .scl_drv_i(scl_drv_i),
    .scl_in_i(scl_in_i), .sts_clr_i(sts_clr_i), .sda_out_o(sda_out_o),
    .scl_out_o(scl_out_o), .arb_lost_o(arb_lost_o), .to_slave_o(to_slave_o),
    .timeout_abort_o(timeout_abort_o), .lowto_sts_o(lowto_sts_o),
    .stretch_o(stretch_o)
  );

  typedef struct {
    logic [6:0] v;   // arb, slv, to, sts, str, sdo, sco
    string      tag;
  } exp_t;

  exp_t sb[$];

  // reference state, kept from the requirement text
  bit m_rel, m_sts, m_sda, m_scl;
  int m_cnt;

  function automatic logic [6:0] outs_now();
    return {arb_lost_o, to_slave_o, timeout_abort_o, lowto_sts_o, stretch_o,
            sda_out_o, scl_out_o};
  endfunction

  task automatic step(input logic [1:0] ph, input logic sd, input logic si,
                      input logic cd, input logic ci, input logic tk,
                      input logic clr, input string tag);
    bit act, st, sp, mis, inc, tmo, nrel;
    exp_t e;
    @(negedge clk);
    phase_i = ph; sda_drv_i = sd; sda_in_i = si;
    scl_drv_i = cd; scl_in_i = ci; tick_i = tk; sts_clr_i = clr;
    act  = (ph != 2'b00);
    st   = ci && m_scl && m_sda && !si;
    sp   = ci && m_scl && !m_sda && si;
    mis  = act && !m_rel && (ph != 2'b11) && ci && (sd != si);          // R1 R2 R3
    inc  = act && !m_rel && tk && !ci && !st && !sp;                    // R7
    tmo  = inc && (m_cnt + 1 == LIM);                                   // R6
    nrel = act && (m_rel || mis || tmo);                                // R5
    e.v  = {mis, mis && (ph == 2'b01), tmo, tmo || (m_sts && !clr),
            act && !m_rel && cd && !ci, nrel || sd, nrel || cd};
    e.tag = tag;
    sb.push_back(e);
    if (!act || st || sp || mis || tmo) m_cnt = 0;                      // R8 R10
    else if (inc) m_cnt = m_cnt + 1;
    m_sts = tmo || (m_sts && !clr);
    m_rel = nrel;
    m_sda = si; m_scl = ci;
  endtask

  // monitor: one expected item per clock, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        logic [6:0] a;
        e = sb.pop_front();
        a = outs_now();
        checks++;
        if (a !== e.v) begin
          errors++;
          $display("FAIL %s: {arb,slv,to,sts,str,sdo,sco} actual=%b expected=%b",
                   e.tag, a, e.v);
        end
      end
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 1, 1, 1, 1, 0, 0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    phase_i = 2'b00; sda_drv_i = 1; sda_in_i = 1; scl_drv_i = 1; scl_in_i = 1;
    tick_i = 0; sts_clr_i = 0;
    m_rel = 0; m_sts = 0; m_sda = 1; m_scl = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    // reset state, R10
    checks++;
    if (outs_now() !== 7'b0000011) begin
      errors++;
      $display("FAIL R10 reset: actual=%b expected=%b", outs_now(), 7'b0000011);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R4: address-phase loss hands over to slave listening
    step(2'b01, 1, 1, 1, 1, 0, 0, "R1");
    step(2'b01, 0, 0, 1, 1, 0, 0, "R1");
    step(2'b01, 0, 0, 0, 0, 0, 0, "R1");
    step(2'b01, 1, 1, 0, 0, 0, 0, "R1");
    step(2'b01, 1, 0, 1, 1, 0, 0, "R4");
    // R5: released, no further pulses, lines forced high
    step(2'b01, 1, 0, 1, 1, 0, 0, "R5");
    step(2'b01, 0, 0, 0, 0, 0, 0, "R5");
    step(2'b01, 0, 0, 0, 0, 1, 0, "R5");
    idle(2, "R5");

    // R1 R4: transmit-phase loss, no hand-over
    step(2'b10, 0, 0, 1, 1, 0, 0, "R1");
    step(2'b10, 1, 1, 0, 0, 0, 0, "R1");
    step(2'b10, 1, 0, 1, 1, 0, 0, "R4");
    idle(2, "R1");

    // R2: mismatch with clock low ignored
    step(2'b10, 0, 0, 1, 1, 0, 0, "R2");
    step(2'b10, 1, 0, 0, 0, 0, 0, "R2");
    step(2'b10, 0, 1, 0, 0, 0, 0, "R2");
    step(2'b10, 0, 0, 1, 1, 0, 0, "R2");
    // R3: receive phase, slave pulls data low with clock high
    step(2'b11, 1, 0, 0, 0, 0, 0, "R3");
    step(2'b11, 1, 0, 1, 1, 0, 0, "R3");
    step(2'b11, 1, 0, 1, 1, 0, 0, "R3");
    idle(2, "R3");

    // R6 R7 R11: cumulative clock-low timeout
    step(2'b10, 0, 0, 1, 1, 0, 0, "R7");
    step(2'b10, 0, 0, 0, 0, 1, 0, "R7");
    step(2'b10, 0, 0, 0, 0, 1, 0, "R7");
    step(2'b10, 0, 0, 0, 0, 1, 0, "R7");
    step(2'b10, 0, 0, 0, 0, 0, 0, "R7");
    step(2'b10, 0, 0, 1, 1, 1, 0, "R7");
    step(2'b10, 0, 0, 1, 1, 1, 0, "R7");
    step(2'b10, 0, 0, 1, 0, 1, 0, "R11");
    step(2'b10, 0, 0, 1, 0, 1, 0, "R11");
    step(2'b10, 0, 0, 1, 0, 1, 0, "R6");
    step(2'b10, 0, 0, 0, 0, 1, 0, "R5");
    // R9: status sticky, then cleared
    step(2'b10, 0, 0, 0, 0, 0, 0, "R9");
    idle(3, "R9");
    step(2'b00, 1, 1, 1, 1, 0, 1, "R9");
    idle(2, "R9");

    // R8: stop and start clear the count
    step(2'b10, 0, 0, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(2'b10, 0, 0, 0, 0, 1, 0, "R8");
    step(2'b10, 0, 0, 1, 1, 0, 0, "R8");
    step(2'b10, 1, 1, 1, 1, 0, 0, "R8");
    step(2'b10, 0, 0, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 5; i++) step(2'b10, 0, 0, 0, 0, 1, 0, "R8");
    idle(2, "R8");

    // R10: idle phase ignores mismatch and clock-low ticks
    for (int i = 0; i < 8; i++) step(2'b00, 1, 1, 1, 0, 1, 0, "R10");
    step(2'b00, 1, 0, 1, 1, 0, 0, "R10");
    idle(2, "R10");

    // R9: timeout and clear in the same cycle, set wins
    step(2'b10, 0, 0, 1, 1, 0, 0, "R9");
    for (int i = 0; i < LIM - 1; i++) step(2'b10, 0, 0, 0, 0, 1, 0, "R6");
    step(2'b10, 0, 0, 0, 0, 1, 1, "R9");
    step(2'b10, 0, 0, 0, 0, 0, 0, "R9");
    step(2'b00, 1, 1, 1, 1, 0, 1, "R9");
    idle(2, "R9");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule